// File: doc/BRIEF.md
# Vector Unpack Lane Sequencer

This block turns a stream of packed elements into individual lane writes for a four-lane (X, Y, Z, W) vector destination. Each cycle it presents at most one lane write, made of a lane index, a datum, a quadword address and a write strobe. A lane write filter downstream accepts or stalls it through a ready signal. Every input element comes with a format code, and that code decides how many lane writes the element produces and whether the element is consumed.

Scalar elements and 16-bit packed 5:5:5:1 colour words always expand into one complete quadword, written X through W. Two-, three- and four-element vectors consume one input element per lane that exists. A stored lane offset survives gaps in the input stream, so a vector whose elements arrive in separate beats picks up at the correct lane. For two- and three-element vectors, the lanes past the format width are written with the last consumed element, and no input is taken for them. The quadword address advances each time a W lane is written.

Top module: `vec_unpack_seq`

## Requirements
- R1: After reset the strobe is low while no element is offered, the address is 0, and the first vector element goes to lane X (lane code 0; X=0, Y=1, Z=2, W=3).
- R2: A scalar element (format code 0) is written unchanged to lanes X, Y, Z and W in that order, and it is accepted only together with the W write.
- R3: A colour word (format code 4) expands to four writes, each zero-extended. X carries bits 4:0 shifted left by 3. Y carries bits 9:5 placed at bits 7:3. Z carries bits 14:10 placed at bits 7:3. W carries bit 15 placed at bit 7.
- R4: A four-element vector (format code 3) writes each accepted element to the current lane offset, and the offset wraps from W back to X.
- R5: A two-element vector (format code 1) consumes elements for X and Y only. It then writes Z and W with the Y element without accepting input, and the offset returns to X.
- R6: A three-element vector (format code 2) consumes elements for X, Y and Z. It then writes W with the Z element without accepting input.
- R7: The lane offset is held while no element is offered, and the next vector element resumes at that lane.
- R8: The address increments by one after each accepted W write and at no other time.
- R9: While the downstream ready is low, the strobe, lane, datum and address hold, and no element is accepted, including during the fill lanes.
- R10: An element with a reserved format code (5, 6 or 7) is accepted with no write, and the lane offset and address are unchanged.
- R11: Scalar and colour expansion always starts at X, even when a vector is partly written, and it leaves the stored vector offset unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An input element is offered |
| in_ready | output | 1 | The offered element is accepted this cycle |
| in_fmt | input | 3 | Format code of the element |
| in_data | input | DW | Element value (colour uses bits 15:0) |
| out_valid | output | 1 | Lane write strobe |
| out_ready | input | 1 | Lane write filter accepts the write |
| out_lane | output | 2 | Lane index of the write |
| out_data | output | DW | Datum of the write |
| out_addr | output | AW | Destination quadword address |

## Verification
Some properties are checked on every cycle. The address steps only on an accepted W write. A scalar or colour element is consumed only on its W write. Nothing is accepted while the filter stalls. The fill lanes of two- and three-element vectors follow directly, carrying the last element, with input held off. The quad offset wraps to X. A reserved code causes no write. Other behaviours can only be shown by the bench's cycle-by-cycle vector table and its directed reset case: the colour field extraction, the exact lane order of each format, an offset resuming after an idle gap, and a scalar that interrupts a half-written vector.

// File: rtl/vec_unpack_seq.sv
module vec_unpack_seq #(
  parameter int DW = 32,
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [2:0]    in_fmt,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [1:0]    out_lane,
  output logic [DW-1:0] out_data,
  output logic [AW-1:0] out_addr
);

  localparam logic [2:0] F_SCALAR = 3'd0;
  localparam logic [2:0] F_PAIR   = 3'd1;
  localparam logic [2:0] F_TRIPLE = 3'd2;
  localparam logic [2:0] F_QUAD   = 3'd3;
  localparam logic [2:0] F_RGBA   = 3'd4;
  localparam logic [1:0] LANE_W   = 2'd3;

  logic [1:0]    lane_off;
  logic [1:0]    exp_lane;
  logic [2:0]    fmt_q;
  logic [DW-1:0] hold;
  logic [AW-1:0] addr;
  logic [7:0]    rgba_b;

  logic fill, is_exp, is_vec, is_bad, fire;

  assign fill   = (fmt_q == F_PAIR && lane_off[1]) || (fmt_q == F_TRIPLE && lane_off == LANE_W);
  assign is_exp = (in_fmt == F_SCALAR) || (in_fmt == F_RGBA);
  assign is_vec = (in_fmt == F_PAIR) || (in_fmt == F_TRIPLE) || (in_fmt == F_QUAD);
  assign is_bad = !is_exp && !is_vec;

  always_comb begin
    case (exp_lane)
      2'd0:    rgba_b = {in_data[4:0], 3'b000};
      2'd1:    rgba_b = {in_data[9:5], 3'b000};
      2'd2:    rgba_b = {in_data[14:10], 3'b000};
      default: rgba_b = {in_data[15], 7'b0000000};
    endcase
  end

  assign out_valid = fill || (in_valid && !is_bad);
  assign out_lane  = (fill || !is_exp) ? lane_off : exp_lane;
  assign out_data  = fill ? hold
                   : (in_fmt == F_RGBA) ? {{(DW-8){1'b0}}, rgba_b}
                   : in_data;
  assign out_addr  = addr;
  assign in_ready  = !fill && (is_bad || (out_ready && (is_vec || exp_lane == LANE_W)));
  assign fire      = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lane_off <= 2'd0;
      exp_lane <= 2'd0;
      fmt_q    <= F_QUAD;
      hold     <= '0;
      addr     <= '0;
    end else if (fire) begin
      if (fill || !is_exp) lane_off <= lane_off + 2'd1;
      if (!fill && is_exp) exp_lane <= exp_lane + 2'd1;
      if (!fill && is_vec) begin
        hold  <= in_data;
        fmt_q <= in_fmt;
      end
      if (out_lane == LANE_W) addr <= addr + 1'b1;
    end
  end

endmodule

// File: rtl/vec_unpack_seq_chk.sv
module vec_unpack_seq_chk #(
  parameter int DW = 32,
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [2:0]    in_fmt,
  input logic [DW-1:0] in_data,
  input logic          out_valid,
  input logic          out_ready,
  input logic [1:0]    out_lane,
  input logic [DW-1:0] out_data,
  input logic [AW-1:0] out_addr
);

  logic fire, take;
  assign fire = out_valid && out_ready;
  assign take = in_valid && in_ready;

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    fire && out_lane == 2'd3 |=> out_addr == $past(out_addr) + 1'b1); // R8

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(fire && out_lane == 2'd3) |=> $stable(out_addr)); // R8

  AST_EXPAND_TAKE_ON_W: assert property (@(posedge clk) disable iff (!rst_n)
    take && (in_fmt == 3'd0 || in_fmt == 3'd4) |-> fire && out_lane == 2'd3); // R2

  AST_PAIR_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    take && in_fmt == 3'd1 && out_lane == 2'd1 |=>
      out_valid && out_lane == 2'd2 && !in_ready && out_data == $past(in_data)); // R5

  AST_TRIPLE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    take && in_fmt == 3'd2 && out_lane == 2'd2 |=>
      out_valid && out_lane == 2'd3 && !in_ready && out_data == $past(in_data)); // R6

  AST_QUAD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    take && in_fmt == 3'd3 && out_lane == 2'd3 |=>
      (out_lane == 2'd0 || in_fmt == 3'd0 || in_fmt == 3'd4)); // R4

  AST_STALL_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && in_fmt <= 3'd4 |-> !in_ready); // R9

  AST_BAD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    take && in_fmt > 3'd4 |-> !out_valid); // R10

endmodule

bind vec_unpack_seq vec_unpack_seq_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_fmt(in_fmt), .in_data(in_data), .out_valid(out_valid),
  .out_ready(out_ready), .out_lane(out_lane), .out_data(out_data),
  .out_addr(out_addr)
);

// File: tb/sim_vec_unpack_seq.sv
module sim_vec_unpack_seq;
  localparam int DW = 32;
  localparam int AW = 16;
  localparam int NROWS = 38;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [2:0]    in_fmt = 3'd3;
  logic [DW-1:0] in_data = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [1:0]    out_lane;
  logic [DW-1:0] out_data;
  logic [AW-1:0] out_addr;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  vec_unpack_seq #(.DW(DW), .AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_fmt(in_fmt), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_lane(out_lane), .out_data(out_data),
    .out_addr(out_addr)
  );

  // row: valid fmt din ordy | exp: strobe lane data addr in_ready
  localparam logic [48:0] TBL [NROWS] = '{
    {1'b1,3'd0,16'h00AA,1'b1, 1'b1,2'd0,16'h00AA,8'd0,1'b0},
    {1'b1,3'd0,16'h00AA,1'b1, 1'b1,2'd1,16'h00AA,8'd0,1'b0},
    {1'b1,3'd0,16'h00AA,1'b1, 1'b1,2'd2,16'h00AA,8'd0,1'b0},
    {1'b1,3'd0,16'h00AA,1'b1, 1'b1,2'd3,16'h00AA,8'd0,1'b1},
    {1'b1,3'd4,16'hABCD,1'b1, 1'b1,2'd0,16'h0068,8'd1,1'b0},
    {1'b1,3'd4,16'hABCD,1'b1, 1'b1,2'd1,16'h00F0,8'd1,1'b0},
    {1'b1,3'd4,16'hABCD,1'b1, 1'b1,2'd2,16'h0050,8'd1,1'b0},
    {1'b1,3'd4,16'hABCD,1'b1, 1'b1,2'd3,16'h0080,8'd1,1'b1},
    {1'b1,3'd3,16'h0011,1'b1, 1'b1,2'd0,16'h0011,8'd2,1'b1},
    {1'b1,3'd3,16'h0022,1'b1, 1'b1,2'd1,16'h0022,8'd2,1'b1},
    {1'b1,3'd3,16'h0033,1'b1, 1'b1,2'd2,16'h0033,8'd2,1'b1},
    {1'b1,3'd3,16'h0044,1'b1, 1'b1,2'd3,16'h0044,8'd2,1'b1},
    {1'b1,3'd1,16'h0055,1'b1, 1'b1,2'd0,16'h0055,8'd3,1'b1},
    {1'b1,3'd1,16'h0066,1'b1, 1'b1,2'd1,16'h0066,8'd3,1'b1},
    {1'b1,3'd2,16'h0077,1'b1, 1'b1,2'd2,16'h0066,8'd3,1'b0},
    {1'b1,3'd2,16'h0077,1'b1, 1'b1,2'd3,16'h0066,8'd3,1'b0},
    {1'b1,3'd2,16'h0077,1'b1, 1'b1,2'd0,16'h0077,8'd4,1'b1},
    {1'b1,3'd2,16'h0088,1'b1, 1'b1,2'd1,16'h0088,8'd4,1'b1},
    {1'b1,3'd2,16'h0099,1'b1, 1'b1,2'd2,16'h0099,8'd4,1'b1},
    {1'b1,3'd3,16'h0012,1'b1, 1'b1,2'd3,16'h0099,8'd4,1'b0},
    {1'b1,3'd3,16'h0012,1'b0, 1'b1,2'd0,16'h0012,8'd5,1'b0},
    {1'b1,3'd3,16'h0012,1'b0, 1'b1,2'd0,16'h0012,8'd5,1'b0},
    {1'b1,3'd3,16'h0012,1'b1, 1'b1,2'd0,16'h0012,8'd5,1'b1},
    {1'b0,3'd3,16'h0000,1'b1, 1'b0,2'd1,16'h0000,8'd5,1'b1},
    {1'b1,3'd3,16'h0013,1'b1, 1'b1,2'd1,16'h0013,8'd5,1'b1},
    {1'b1,3'd0,16'h005A,1'b1, 1'b1,2'd0,16'h005A,8'd5,1'b0},
    {1'b1,3'd0,16'h005A,1'b1, 1'b1,2'd1,16'h005A,8'd5,1'b0},
    {1'b1,3'd0,16'h005A,1'b1, 1'b1,2'd2,16'h005A,8'd5,1'b0},
    {1'b1,3'd0,16'h005A,1'b1, 1'b1,2'd3,16'h005A,8'd5,1'b1},
    {1'b1,3'd3,16'h0014,1'b1, 1'b1,2'd2,16'h0014,8'd6,1'b1},
    {1'b1,3'd3,16'h0015,1'b1, 1'b1,2'd3,16'h0015,8'd6,1'b1},
    {1'b1,3'd5,16'h00FF,1'b1, 1'b0,2'd0,16'h00FF,8'd7,1'b1},
    {1'b1,3'd3,16'h0016,1'b1, 1'b1,2'd0,16'h0016,8'd7,1'b1},
    {1'b1,3'd1,16'h0021,1'b1, 1'b1,2'd1,16'h0021,8'd7,1'b1},
    {1'b1,3'd3,16'h0030,1'b0, 1'b1,2'd2,16'h0021,8'd7,1'b0},
    {1'b1,3'd3,16'h0030,1'b1, 1'b1,2'd2,16'h0021,8'd7,1'b0},
    {1'b1,3'd3,16'h0030,1'b1, 1'b1,2'd3,16'h0021,8'd7,1'b0},
    {1'b0,3'd3,16'h0000,1'b1, 1'b0,2'd0,16'h0000,8'd8,1'b1}
  };

  function automatic string tag_of(int i);
    if (i < 4)  return "R2";
    if (i < 8)  return "R3";
    if (i < 12) return "R4";
    if (i < 16) return "R5";
    if (i < 20) return "R6";
    if (i < 23) return "R9";
    if (i < 25) return "R7";
    if (i < 31) return "R11";
    if (i < 33) return "R10";
    if (i < 34) return "R5";
    if (i < 37) return "R9";
    return "R8";
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [45:0] act;
    logic [45:0] exp;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: idle after reset
    check(!out_valid && out_addr == '0, "R1",
          {out_valid, out_addr}, {1'b0, 16'h0000});

    for (int i = 0; i < NROWS; i++) begin
      @(negedge clk);
      in_valid  = TBL[i][48];
      in_fmt    = TBL[i][47:45];
      in_data   = {16'h0000, TBL[i][44:29]};
      out_ready = TBL[i][28];
      #1;
      act = {out_valid, out_lane, out_data[15:0], out_addr[7:0], in_ready, 18'h0};
      exp = {TBL[i][27], TBL[i][26:25], TBL[i][24:9], TBL[i][8:1], TBL[i][0], 18'h0};
      check(act == exp && out_data[31:16] == 16'h0000 && out_addr[15:8] == 8'h00,
            tag_of(i), {18'h0, act}, {18'h0, exp});
    end

    // R1: reset in the middle of a vector
    @(negedge clk);
    in_valid = 1'b1; in_fmt = 3'd3; in_data = 32'h40; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(!out_valid && out_addr == '0, "R1",
          {out_valid, out_addr}, {1'b0, 16'h0000});
    @(negedge clk);
    in_valid = 1'b1; in_fmt = 3'd3; in_data = 32'h41;
    #1;
    check(out_valid && out_lane == 2'd0 && out_data == 32'h41 && in_ready, "R1",
          {out_valid, out_lane, out_data}, {1'b1, 2'd0, 32'h41});
    @(negedge clk);
    in_valid = 1'b0;
    finish_run();
  end
endmodule